// File: doc/BRIEF.md
# Descriptor Pointer Queue Manager

This block keeps a set of hardware queues of descriptor pointers. Each queue is a singly linked list of descriptor indices. The links live in an internal link memory, and each queue has its own head pointer, tail pointer and entry count. Software adds a descriptor by writing its byte address to the queue's access register. It takes one out by reading that same register, which returns zero when the queue holds nothing.

A single descriptor region turns byte addresses into link indices and back. The region is set by a base address, a first index, a size code and a capacity code. A pushed address that does not name a descriptor of the region is discarded, and a sticky error flag is raised.

The register port has separate write and read channels, so a push and a pop can arrive in the same cycle. Read data comes back one cycle after the read strobe.

Top module: `desc_queue_mgr`

## Requirements
- R1: Each queue is first-in first-out. A read of access register q (word address q, 0..15) pops the oldest descriptor. `rdValid` and `rdData` are registered and appear in the cycle after `rdEn`. When no read was issued in the previous cycle, `rdValid` is 0 and `rdData` is 0.
- R2: A popped word carries the descriptor address in bits [31:4] and the region size code in bits [3:0]. The low nibble of a pushed word is ignored.
- R3: A pop of an empty queue returns 0 and leaves the queue empty. Popping until zero comes back drains the queue.
- R4: A pushed address A maps to index start + (A - base) / ((sizeCode+1)*16). A pop turns the index back into the same address.
- R5: A push is discarded and `errFlag` is set in the next cycle when any of these holds: the address lies below the base; the index offset reaches the capacity 32 << countCode; or the index reaches the link depth of 256. A discarded push leaves the queue count unchanged. `errFlag` never rises without a write.
- R6: A push is discarded and `errFlag` is set when (A - base) is not a whole multiple of the descriptor size.
- R7: While the base register holds zero, the region is unconfigured and every push is discarded with `errFlag` set.
- R8: A read of word address 16+q returns the current entry count of queue q.
- R9: `errFlag` stays set until a write to word address 35. It reads back in bit 0 of address 35.
- R10: When a push and a pop reach the same queue in one cycle, the push takes effect first. On an empty queue the pop returns the pushed descriptor and the count stays 0. Otherwise the pop returns the head and the count is unchanged.
- R11: Queues are independent: traffic on one queue does not alter the content or order of another.
- R12: The region registers read back as follows. Address 32 gives the base, with bits [3:0] reading 0. Address 33 gives the first index. Address 34 gives the size code in bits [19:16] and the capacity code in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 6 | Write word address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 6 | Read word address |
| rdData | output | 32 | Read data, one cycle after rdEn |
| rdValid | output | 1 | Read data valid |
| errFlag | output | 1 | Sticky dropped-push flag |

## Verification
Every read result is due exactly one cycle after its strobe. The driver queues the expected word when it raises `rdEn`, and the monitor takes the result at the next falling edge, when `rdValid` is high. A push changes the counts and the error flag at the next rising edge. The bench therefore samples `errFlag` and issues count reads only on the falling edge after the write strobe has dropped. For a same-cycle push and pop, the expected pop value is queued in the same cycle, and the monitor receives it one cycle later like any other read.

// File: rtl/desc_qm_pkg.sv
package desc_qm_pkg;
  parameter int NUM_QUEUES = 16;
  parameter int LINK_DEPTH = 256;

  localparam int QW     = $clog2(NUM_QUEUES);
  localparam int IW     = $clog2(LINK_DEPTH);
  localparam int CW     = IW + 1;
  localparam int AW     = QW + 2;
  localparam int DW     = IW + 4;
  localparam int LINE_W = 28;

  localparam logic [1:0] WIN_QUEUE = 2'd0;
  localparam logic [1:0] WIN_COUNT = 2'd1;
  localparam logic [1:0] WIN_CFG   = 2'd2;

  localparam logic [1:0] CFG_BASE  = 2'd0;
  localparam logic [1:0] CFG_START = 2'd1;
  localparam logic [1:0] CFG_SIZE  = 2'd2;
  localparam logic [1:0] CFG_ERR   = 2'd3;

  typedef struct packed {
    logic          pushEn;
    logic [QW-1:0] pushQ;
    logic [IW-1:0] pushIdx;
    logic          popEn;
    logic [QW-1:0] popQ;
  } qmStrobe_t;
endpackage

// File: rtl/desc_qm_datapath.sv
module desc_qm_datapath
  import desc_qm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  qmStrobe_t     strobe,
  input  logic [QW-1:0] statQ,
  output logic          popValid,
  output logic [IW-1:0] popIdx,
  output logic [CW-1:0] statCnt
);
  logic [IW-1:0] linkRam  [LINK_DEPTH];
  logic [IW-1:0] headIdx  [NUM_QUEUES];
  logic [IW-1:0] tailIdx  [NUM_QUEUES];
  logic [CW-1:0] entryCnt [NUM_QUEUES];

  logic          sameQ;
  logic [CW-1:0] pushCnt;
  logic [CW-1:0] popCnt;

  always_comb begin
    sameQ    = strobe.pushEn && strobe.popEn && (strobe.pushQ == strobe.popQ);
    pushCnt  = entryCnt[strobe.pushQ];
    popCnt   = entryCnt[strobe.popQ];
    popValid = strobe.popEn && ((popCnt != '0) || sameQ);
    popIdx   = (popCnt == '0) ? strobe.pushIdx : headIdx[strobe.popQ];
    statCnt  = entryCnt[statQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) entryCnt[q] <= '0;
    end else if (!sameQ) begin
      if (strobe.pushEn) entryCnt[strobe.pushQ] <= pushCnt + 1'b1;
      if (strobe.popEn && popCnt != '0) entryCnt[strobe.popQ] <= popCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sameQ) begin
      if (pushCnt == CW'(1)) begin
        headIdx[strobe.pushQ] <= strobe.pushIdx;
        tailIdx[strobe.pushQ] <= strobe.pushIdx;
      end else if (pushCnt > CW'(1)) begin
        linkRam[tailIdx[strobe.pushQ]] <= strobe.pushIdx;
        tailIdx[strobe.pushQ]          <= strobe.pushIdx;
        headIdx[strobe.pushQ]          <= linkRam[headIdx[strobe.pushQ]];
      end
    end else begin
      if (strobe.pushEn) begin
        if (pushCnt == '0) headIdx[strobe.pushQ] <= strobe.pushIdx;
        else linkRam[tailIdx[strobe.pushQ]] <= strobe.pushIdx;
        tailIdx[strobe.pushQ] <= strobe.pushIdx;
      end
      if (strobe.popEn && popCnt != '0)
        headIdx[strobe.popQ] <= linkRam[headIdx[strobe.popQ]];
    end
  end
endmodule

// File: rtl/desc_qm_ctrl.sv
module desc_qm_ctrl
  import desc_qm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [31:0]   wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output qmStrobe_t     strobe,
  output logic [QW-1:0] statQ,
  input  logic          popValid,
  input  logic [IW-1:0] popIdx,
  input  logic [CW-1:0] statCnt,
  output logic [31:0]   rdData,
  output logic          rdValid,
  output logic          errFlag
);
  logic [LINE_W-1:0] baseLine;
  logic [IW-1:0]     startIdx;
  logic [3:0]        sizeCode;
  logic [3:0]        countCode;

  logic [1:0] wrWin, rdWin;
  logic       pushReq, pushOk, cfgWr, errClr;
  logic [LINE_W-1:0] descLine, offLine, lineOff, popLine;
  logic [4:0]  unitLines;
  logic [DW-1:0] quot;
  logic [5:0]  remain;
  logic [DW:0] idxSum;
  logic        belowBase, farOut, overCap, overDepth;
  logic [IW-1:0] relIdx;
  logic [31:0] rdMux;

  assign wrWin     = wrAddr[AW-1:QW];
  assign rdWin     = rdAddr[AW-1:QW];
  assign statQ     = rdAddr[QW-1:0];
  assign unitLines = {1'b0, sizeCode} + 5'd1;
  assign descLine  = wrData[31:4];

  // address to index: restoring division by the descriptor size in 16-byte lines
  always_comb begin
    belowBase = descLine < baseLine;
    offLine   = descLine - baseLine;
    farOut    = offLine[LINE_W-1:DW] != '0;
    remain    = '0;
    quot      = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      remain = {remain[4:0], offLine[i]};
      if (remain >= {1'b0, unitLines}) begin
        remain  = remain - {1'b0, unitLines};
        quot[i] = 1'b1;
      end
    end
    overCap   = (quot >> (5'd5 + {1'b0, countCode})) != '0;
    idxSum    = (DW+1)'(startIdx) + (DW+1)'(quot);
    overDepth = idxSum >= (DW+1)'(LINK_DEPTH);
    pushReq   = wrEn && (wrWin == WIN_QUEUE);
    pushOk    = (baseLine != '0) && !belowBase && !farOut && (remain == '0)
                && !overCap && !overDepth;
    cfgWr     = wrEn && (wrWin == WIN_CFG);
    errClr    = cfgWr && (wrAddr[1:0] == CFG_ERR);
  end

  always_comb begin
    strobe.pushEn  = pushReq && pushOk;
    strobe.pushQ   = wrAddr[QW-1:0];
    strobe.pushIdx = idxSum[IW-1:0];
    strobe.popEn   = rdEn && (rdWin == WIN_QUEUE);
    strobe.popQ    = rdAddr[QW-1:0];
  end

  // index to address for pops
  always_comb begin
    relIdx  = popIdx - startIdx;
    lineOff = LINE_W'(relIdx) * LINE_W'(unitLines);
    popLine = baseLine + lineOff;
    rdMux   = '0;
    case (rdWin)
      WIN_QUEUE: rdMux = popValid ? {popLine, sizeCode} : 32'd0;
      WIN_COUNT: rdMux = 32'(statCnt);
      WIN_CFG: begin
        case (rdAddr[1:0])
          CFG_BASE:  rdMux = {baseLine, 4'd0};
          CFG_START: rdMux = 32'(startIdx);
          CFG_SIZE:  rdMux = {12'd0, sizeCode, 12'd0, countCode};
          default:   rdMux = {31'd0, errFlag};
        endcase
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLine  <= '0;
      startIdx  <= '0;
      sizeCode  <= '0;
      countCode <= '0;
      errFlag   <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      rdValid <= rdEn;
      rdData  <= rdEn ? rdMux : 32'd0;
      if (pushReq && !pushOk) errFlag <= 1'b1;
      else if (errClr)        errFlag <= 1'b0;
      if (cfgWr) begin
        case (wrAddr[1:0])
          CFG_BASE:  baseLine <= wrData[31:4];
          CFG_START: startIdx <= wrData[IW-1:0];
          CFG_SIZE: begin
            sizeCode  <= wrData[19:16];
            countCode <= wrData[3:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
  import desc_qm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [31:0]   wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [31:0]   rdData,
  output logic          rdValid,
  output logic          errFlag
);
  qmStrobe_t     strobe;
  logic [QW-1:0] statQ;
  logic          popValid;
  logic [IW-1:0] popIdx;
  logic [CW-1:0] statCnt;

  desc_qm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe), .statQ(statQ),
    .popValid(popValid), .popIdx(popIdx), .statCnt(statCnt),
    .rdData(rdData), .rdValid(rdValid), .errFlag(errFlag)
  );

  desc_qm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statQ(statQ),
    .popValid(popValid), .popIdx(popIdx), .statCnt(statCnt)
  );
endmodule

// File: rtl/desc_queue_mgr_checker.sv
module desc_queue_mgr_checker
  import desc_qm_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic          rdEn,
  input logic [AW-1:0] rdAddr,
  input logic [31:0]   rdData,
  input logic          rdValid,
  input logic          errFlag
);
  localparam logic [AW-1:0] ERR_ADDR  = AW'(2*NUM_QUEUES + 3);
  localparam logic [AW-1:0] BASE_ADDR = AW'(2*NUM_QUEUES);

  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R1
  AST_RD_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (!rdValid && rdData == 32'd0)); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(wrEn && wrAddr == ERR_ADDR)) |=> errFlag); // R9
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ERR_ADDR) |=> !errFlag); // R9
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !wrEn) |=> !errFlag); // R5
  AST_BASE_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == BASE_ADDR) |=> rdData[3:0] == 4'd0); // R12
endmodule

bind desc_queue_mgr desc_queue_mgr_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .errFlag(errFlag)
);

// File: tb/desc_queue_mgr_bench.sv
module desc_queue_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_BASE = 16;
  localparam int CFG_BASE_A = 32;
  localparam int CFG_START_A = 33;
  localparam int CFG_SIZE_A = 34;
  localparam int CFG_ERR_A = 35;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [5:0] rdAddr = '0;
  logic [31:0] rdData;
  logic rdValid;
  logic errFlag;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [31:0] expVal[$];
  string expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_queue_mgr u_desc_queue_mgr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compare every returned read against the scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expVal.size() == 0) check(1'b0, "R1 unexpected read data", rdData, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = expVal.pop_front();
        t = expTag.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    wrEn = 1'b1; wrAddr = 6'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    rdEn = 1'b1; rdAddr = 6'(addr);
    expVal.push_back(exp); expTag.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pushPop(input int q, input logic [31:0] data, input logic [31:0] exp,
                         input string tag);
    wrEn = 1'b1; wrAddr = 6'(q); wrData = data;
    rdEn = 1'b1; rdAddr = 6'(q);
    expVal.push_back(exp); expTag.push_back(tag);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic errIs(input bit exp, input string tag);
    check(errFlag === exp, tag, 32'(errFlag), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(errFlag === 1'b0, "R9 reset errFlag", 32'(errFlag), 0);
    check(rdValid === 1'b0, "R1 reset rdValid", 32'(rdValid), 0);
    rd(CNT_BASE + 0, 0, "R8 reset count");
    rd(0, 0, "R3 pop empty after reset");
    wr(1, 32'h0000_1000);
    errIs(1'b1, "R7 push while unconfigured");
    wr(CFG_ERR_A, 0);
    errIs(1'b0, "R9 clear");

    wr(CFG_BASE_A, 32'h0000_1007);
    wr(CFG_START_A, 0);
    wr(CFG_SIZE_A, 32'h0000_0000);
    rd(CFG_BASE_A, 32'h0000_1000, "R12 base readback");
    rd(CFG_SIZE_A, 0, "R12 size word readback");

    wr(1, 32'h0000_1005);
    wr(1, 32'h0000_1010);
    wr(1, 32'h0000_102F);
    errIs(1'b0, "R1 good pushes no error");
    rd(CNT_BASE + 1, 3, "R8 count after three pushes");
    rd(1, 32'h0000_1000, "R2 first pop nibble is size code");
    rd(1, 32'h0000_1010, "R1 fifo order second");
    rd(1, 32'h0000_1020, "R1 fifo order third");
    rd(1, 0, "R3 drained returns zero");
    rd(CNT_BASE + 1, 0, "R3 drained count");

    wr(2, 32'h0000_1030);
    wr(3, 32'h0000_1040);
    wr(2, 32'h0000_1050);
    rd(3, 32'h0000_1040, "R11 queue 3 own item");
    rd(2, 32'h0000_1030, "R11 queue 2 head");
    rd(2, 32'h0000_1050, "R11 queue 2 second");

    wr(4, 32'h0000_0FF0);
    errIs(1'b1, "R5 below base");
    rd(CFG_ERR_A, 1, "R9 error readback");
    rd(CNT_BASE + 4, 0, "R5 below base not queued");
    wr(CFG_ERR_A, 0);
    errIs(1'b0, "R9 cleared");
    wr(4, 32'h0000_1200);
    errIs(1'b1, "R5 beyond capacity");
    wr(CFG_ERR_A, 0);
    wr(4, 32'h0000_11F0);
    errIs(1'b0, "R5 last index inside capacity");
    rd(4, 32'h0000_11F0, "R5 last index pops back");

    wr(CFG_SIZE_A, 32'h0002_0003);
    wr(CFG_START_A, 10);
    rd(CFG_START_A, 10, "R12 start readback");
    rd(CFG_SIZE_A, 32'h0002_0003, "R12 size fields readback");
    wr(5, 32'h0000_1000);
    wr(5, 32'h0000_1030);
    wr(5, 32'h0000_3DF0);
    errIs(1'b0, "R4 48-byte pushes accepted");
    wr(5, 32'h0000_3E20);
    errIs(1'b1, "R5 index past link depth");
    wr(CFG_ERR_A, 0);
    wr(5, 32'h0000_1010);
    errIs(1'b1, "R6 offset not a multiple of size");
    wr(CFG_ERR_A, 0);
    rd(CNT_BASE + 5, 3, "R5 R6 dropped pushes not counted");
    rd(5, 32'h0000_1002, "R4 index 10 maps back");
    rd(5, 32'h0000_1032, "R4 index 11 maps back");
    rd(5, 32'h0000_3DF2, "R4 index 255 maps back");

    pushPop(6, 32'h0000_1060, 32'h0000_1062, "R10 push and pop on empty");
    rd(CNT_BASE + 6, 0, "R10 empty bypass count");
    wr(6, 32'h0000_1090);
    pushPop(6, 32'h0000_10C0, 32'h0000_1092, "R10 push and pop returns head");
    rd(CNT_BASE + 6, 1, "R10 count unchanged");
    wr(6, 32'h0000_10F0);
    pushPop(6, 32'h0000_1120, 32'h0000_10C2, "R10 longer list head");
    rd(6, 32'h0000_10F2, "R10 order kept");
    rd(6, 32'h0000_1122, "R10 pushed item last");

    wr(CFG_BASE_A, 0);
    wr(7, 32'h0000_1000);
    errIs(1'b1, "R7 cleared base drops push");
    rd(CNT_BASE + 7, 0, "R7 nothing queued");
    rd(7, 0, "R7 pop returns zero");
    wr(CFG_ERR_A, 0);

    repeat (3) @(negedge clk);
    check(expVal.size() == 0, "R1 all reads answered", 32'(expVal.size()), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule